// File: doc/BRIEF.md
# Ordered-Key Access Unlock Gate

This block guards the protected information region of a flash controller. Software opens the region by writing three fixed 32-bit key words, in a set order, to one write-only register on a simple 32-bit register bus. After the third key, an unlock flag rises. While that flag is set, accesses to the protected region pass through to the array. While it is clear, those accesses are stopped and reported.

When a wrong word is written part way through the sequence, progress goes back to the start. The exception is a wrong word that equals the opening key: it counts as a new first step. Once the region is open, any write to the key register closes it again. A read of the key register never shows the keys or the progress; it always returns zero.

When an access to the protected region is attempted while the region is closed, it is not forwarded. Its read data is forced to zero, and a one-cycle violation pulse is raised on the following cycle.

Top module: `keyseq_gate`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `unlocked` is 0, `prot_viol` is 0, and no key step has been taken.
- R2: Three writes to the key register (offset 0x40) carrying 0x3a7f5ca3, then 0xa1e34f20, then 0x9608b2c1 set `unlocked` to 1. The flag becomes visible in the cycle after the third write.
- R3: A write to the key register whose value is not the next expected key clears progress, so the sequence must restart from the first key. Partial or reordered sequences leave `unlocked` at 0.
- R4: A wrong write whose value equals the first key (0x3a7f5ca3) counts as the first step of a new sequence.
- R5: While `unlocked` is 1, a write of any value to the key register clears `unlocked` in the next cycle and clears any progress.
- R6: A read of the key register raises `reg_rvalid` one cycle later with `reg_rdata` equal to 0, whatever the lock state or progress. Reads do not change progress.
- R7: Writes to any offset other than 0x40, including writes of key values, change neither progress nor `unlocked`.
- R8: While `unlocked` is 1:
  - a `prot_req` drives `flash_req` in the same cycle;
  - `flash_we` follows `prot_we`;
  - `prot_rdata` equals `flash_rdata`.
- R9: While `unlocked` is 0:
  - `flash_req` and `flash_we` stay 0;
  - `prot_rdata` is 0;
  - every cycle with `prot_req` high produces `prot_viol` high in the following cycle;
  - `prot_viol` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register bus write strobe |
| reg_rd | input | 1 | Register bus read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the key register (always zero) |
| reg_rvalid | output | 1 | Read response for the key register, one cycle after the read |
| unlocked | output | 1 | Protected region open |
| prot_req | input | 1 | Access request to the protected region |
| prot_we | input | 1 | Request is a write |
| flash_rdata | input | 32 | Read data returned by the array |
| flash_req | output | 1 | Request forwarded to the array |
| flash_we | output | 1 | Forwarded write qualifier |
| prot_rdata | output | 32 | Read data returned to the requester |
| prot_viol | output | 1 | One-cycle pulse for a blocked access |

## Verification
The hardest situations to reach are those where a stray word lands in the middle of a sequence. One case is a repeat of the opening key after progress has started; another is a valid key written to the wrong offset between two good writes. Either one must leave progress at exactly the right step. The stimulus builds these sequences on purpose: opening key twice, opening key in the middle position, a key value sent to a neighbouring offset, and reads placed between key writes. A final correct key then shows, through `unlocked`, which step each stray write left behind.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_KEYS = 3;
    localparam int STEP_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1;

    typedef logic [WORD_W-1:0] word_t;

    // Ordered unlock keys; index is the step at which each must arrive.
    localparam word_t UNLOCK_KEYS [NUM_KEYS] = '{
        32'h3a7f5ca3,
        32'ha1e34f20,
        32'h9608b2c1
    };

    typedef struct packed {
        logic              open;
        logic [STEP_W-1:0] step;
    } seq_state_t;

    typedef struct packed {
        logic  key_wr;
        logic  key_rd;
        word_t wdata;
    } key_evt_t;

    localparam seq_state_t SEQ_RESET = '{open: 1'b0, step: '0};

    // Next sequence state for one write to the key register.
    function automatic seq_state_t advance(seq_state_t cur,
                                           logic match_cur,
                                           logic match_first);
        seq_state_t nxt;
        nxt = SEQ_RESET;
        if (cur.open) begin
            nxt = SEQ_RESET;
        end else if (match_cur) begin
            if (cur.step == STEP_W'(NUM_KEYS - 1)) begin
                nxt.open = 1'b1;
                nxt.step = '0;
            end else begin
                nxt.step = cur.step + 1'b1;
            end
        end else if (match_first) begin
            nxt.step = STEP_W'(1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/keyseq_tracker.sv
module keyseq_tracker
    import keyseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  key_evt_t evt,
    output logic     open_o
);

    logic [NUM_KEYS-1:0] key_match;
    seq_state_t          cur_q;
    seq_state_t          nxt;

    genvar g;
    generate
        for (g = 0; g < NUM_KEYS; g++) begin : g_key_cmp
            assign key_match[g] = (evt.wdata == UNLOCK_KEYS[g]);
        end
    endgenerate

    always_comb begin
        nxt = cur_q;
        if (evt.key_wr) begin
            nxt = advance(cur_q, key_match[cur_q.step], key_match[0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= SEQ_RESET;
        end else begin
            cur_q <= nxt;
        end
    end

    assign open_o = cur_q.open;

endmodule

// File: rtl/keyseq_guard.sv
module keyseq_guard
    import keyseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  open_i,
    input  logic  prot_req,
    input  logic  prot_we,
    input  word_t flash_rdata,
    output logic  flash_req,
    output logic  flash_we,
    output word_t prot_rdata,
    output logic  prot_viol
);

    logic viol_q;

    assign flash_req  = prot_req & open_i;
    assign flash_we   = prot_req & prot_we & open_i;
    assign prot_rdata = open_i ? flash_rdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= prot_req & ~open_i;
        end
    end

    assign prot_viol = viol_q;

endmodule

// File: rtl/keyseq_rdport.sv
module keyseq_rdport
    import keyseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  key_rd,
    output logic  rvalid,
    output word_t rdata
);

    logic rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= key_rd;
        end
    end

    assign rvalid = rvalid_q;
    // Key words and progress are never exposed on readback.
    assign rdata  = '0;

endmodule

// File: rtl/keyseq_gate.sv
module keyseq_gate
    import keyseq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] KEY_OFS = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              unlocked,
    input  logic              prot_req,
    input  logic              prot_we,
    input  logic [31:0]       flash_rdata,
    output logic              flash_req,
    output logic              flash_we,
    output logic [31:0]       prot_rdata,
    output logic              prot_viol
);

    logic     key_hit;
    key_evt_t evt;
    logic     open_w;

    assign key_hit = (reg_addr == KEY_OFS);

    always_comb begin
        evt.key_wr = reg_wr & key_hit;
        evt.key_rd = reg_rd & key_hit;
        evt.wdata  = reg_wdata;
    end

    keyseq_tracker u_tracker (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .open_o (open_w)
    );

    keyseq_guard u_guard (
        .clk         (clk),
        .rst         (rst),
        .open_i      (open_w),
        .prot_req    (prot_req),
        .prot_we     (prot_we),
        .flash_rdata (flash_rdata),
        .flash_req   (flash_req),
        .flash_we    (flash_we),
        .prot_rdata  (prot_rdata),
        .prot_viol   (prot_viol)
    );

    keyseq_rdport u_rdport (
        .clk    (clk),
        .rst    (rst),
        .key_rd (evt.key_rd),
        .rvalid (reg_rvalid),
        .rdata  (reg_rdata)
    );

    assign unlocked = open_w;

endmodule

// File: rtl/keyseq_chk.sv
module keyseq_chk
    import keyseq_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] KEY_OFS = 8'h40
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              reg_rvalid,
    input logic              unlocked,
    input logic              prot_req,
    input logic              prot_we,
    input logic              flash_req,
    input logic              flash_we,
    input logic [31:0]       prot_rdata,
    input logic              prot_viol
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!unlocked && !prot_viol));

    // R2
    open_after_last_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(reg_wr && reg_addr == KEY_OFS
                                  && reg_wdata == UNLOCK_KEYS[NUM_KEYS-1]));

    // R5
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && reg_wr && reg_addr == KEY_OFS) |=> !unlocked);

    // R6
    read_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == KEY_OFS) |=> (reg_rvalid && reg_rdata == 32'h0));

    // R7
    foreign_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr != KEY_OFS) |=> $stable(unlocked));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (unlocked && prot_req) |-> (flash_req && (flash_we == prot_we)));

    // R9
    blocked_chk: assert property (@(posedge clk) disable iff (rst)
        !unlocked |-> (!flash_req && !flash_we && prot_rdata == 32'h0));

    // R9
    viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (prot_req && !unlocked) |=> prot_viol);

    // R9
    viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
        prot_viol |-> $past(prot_req && !unlocked));

endmodule

bind keyseq_gate keyseq_chk #(
    .ADDR_W  (ADDR_W),
    .KEY_OFS (KEY_OFS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid),
    .unlocked   (unlocked),
    .prot_req   (prot_req),
    .prot_we    (prot_we),
    .flash_req  (flash_req),
    .flash_we   (flash_we),
    .prot_rdata (prot_rdata),
    .prot_viol  (prot_viol)
);

// File: tb/sim_keyseq_gate.sv
module sim_keyseq_gate;

    localparam logic [7:0]  KOFS = 8'h40;
    localparam logic [31:0] KA   = 32'h3a7f5ca3;
    localparam logic [31:0] KB   = 32'ha1e34f20;
    localparam logic [31:0] KC   = 32'h9608b2c1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, unlocked;
    logic        prot_req = 1'b0, prot_we = 1'b0;
    logic [31:0] flash_rdata = '0;
    logic        flash_req, flash_we, prot_viol;
    logic [31:0] prot_rdata;

    always #10 clk = ~clk;

    keyseq_gate u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .unlocked(unlocked), .prot_req(prot_req),
        .prot_we(prot_we), .flash_rdata(flash_rdata), .flash_req(flash_req),
        .flash_we(flash_we), .prot_rdata(prot_rdata), .prot_viol(prot_viol)
    );

    typedef enum {K_UNLK, K_VIOL, K_FREQ, K_FWE, K_PRD, K_RVALID, K_RDATA} kind_e;
    typedef struct {
        int          cyc;
        kind_e       kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    bit    ref_open = 1'b0;
    int    ref_step = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] key_of(int i);
        return (i == 0) ? KA : (i == 1) ? KB : KC;
    endfunction

    function automatic logic [31:0] observe(kind_e k);
        case (k)
            K_UNLK:   return {31'b0, unlocked};
            K_VIOL:   return {31'b0, prot_viol};
            K_FREQ:   return {31'b0, flash_req};
            K_FWE:    return {31'b0, flash_we};
            K_PRD:    return prot_rdata;
            K_RVALID: return {31'b0, reg_rvalid};
            default:  return reg_rdata;
        endcase
    endfunction

    task automatic push(int c, kind_e k, logic [31:0] e, string r);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    // Expected lock state from the requirement text (R2..R5, R7).
    task automatic ref_write(logic [7:0] a, logic [31:0] d);
        if (a == KOFS) begin
            if (ref_open) begin
                ref_open = 1'b0; ref_step = 0;
            end else if (d == key_of(ref_step)) begin
                if (ref_step == 2) begin
                    ref_open = 1'b1; ref_step = 0;
                end else begin
                    ref_step++;
                end
            end else begin
                ref_step = (d == KA) ? 1 : 0;
            end
        end
    endtask

    // Monitor: pops every item due in the current cycle, before the next edge.
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            @(negedge clk);
            #8;
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                it  = sbq.pop_front();
                act = observe(it.kind);
                n_chk++;
                if (it.cyc != cyc || act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s: %s cycle %0d actual %h expected %h",
                             it.req, it.kind.name(), cyc, act, it.exp);
                end
            end
        end
    end

    task automatic reg_write(logic [7:0] a, logic [31:0] d, string r);
        @(negedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        ref_write(a, d);
        push(cyc + 1, K_UNLK, {31'b0, ref_open}, r);
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [7:0] a, string r);
        @(negedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        push(cyc + 1, K_RVALID, {31'b0, (a == KOFS)}, r);
        push(cyc + 1, K_RDATA, 32'h0, r);
        push(cyc + 1, K_UNLK, {31'b0, ref_open}, r);
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic access(logic we, logic [31:0] fd, string r);
        @(negedge clk); #1;
        prot_req = 1'b1; prot_we = we; flash_rdata = fd;
        push(cyc, K_FREQ, {31'b0, ref_open}, r);
        push(cyc, K_FWE, {31'b0, ref_open & we}, r);
        push(cyc, K_PRD, ref_open ? fd : 32'h0, r);
        push(cyc + 1, K_VIOL, {31'b0, ~ref_open}, r);
        @(posedge clk); #1;
        prot_req = 1'b0; prot_we = 1'b0;
    endtask

    task automatic quiet(string r);
        @(negedge clk); #1;
        push(cyc + 1, K_VIOL, 32'h0, r);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: held in reset
        push(cyc, K_UNLK, 32'h0, "R1");
        push(cyc, K_VIOL, 32'h0, "R1");
        @(posedge clk); #1;
        rst = 1'b0;
        push(cyc, K_UNLK, 32'h0, "R1");
        push(cyc, K_VIOL, 32'h0, "R1");
        // R1: no step taken, second key alone does nothing
        reg_write(KOFS, KB, "R1");
        reg_write(KOFS, KC, "R1");

        // R9: blocked read and write while locked
        access(1'b0, 32'hdeadbeef, "R9");
        access(1'b1, 32'h12345678, "R9");
        quiet("R9");

        // R3: wrong third word, then partial restart
        reg_write(KOFS, KA, "R3");
        reg_write(KOFS, KB, "R3");
        reg_write(KOFS, 32'h0000_0001, "R3");
        reg_write(KOFS, KC, "R3");
        // R3: reordered keys
        reg_write(KOFS, KB, "R3");
        reg_write(KOFS, KA, "R3");
        reg_write(KOFS, KC, "R3");

        // R4: repeated first key still opens
        reg_write(KOFS, KA, "R4");
        reg_write(KOFS, KA, "R4");
        reg_write(KOFS, KB, "R4");
        reg_write(KOFS, KC, "R4");
        // R5: any value relocks
        reg_write(KOFS, 32'h0, "R5");
        // R4: first key in the middle slot restarts at step one
        reg_write(KOFS, KA, "R4");
        reg_write(KOFS, KB, "R4");
        reg_write(KOFS, KA, "R4");
        reg_write(KOFS, KB, "R4");
        reg_write(KOFS, KC, "R4");
        // R5: writing the last key again while open relocks
        reg_write(KOFS, KC, "R5");

        // R7: key values to other offsets are ignored
        reg_write(8'h44, KA, "R7");
        reg_write(8'h3c, KB, "R7");
        reg_write(8'h00, KC, "R7");
        reg_write(KOFS, KA, "R7");
        reg_write(8'h44, KA, "R7");
        reg_write(KOFS, KB, "R7");
        reg_read(KOFS, "R6");
        reg_write(8'h30, 32'hffff_ffff, "R7");
        reg_write(KOFS, KC, "R7");
        reg_write(8'h40 ^ 8'h80, 32'h0, "R7");

        // R8: open region forwards accesses and data
        access(1'b0, 32'hcafe_f00d, "R8");
        access(1'b1, 32'h0bad_0bad, "R8");
        quiet("R8");
        // R6: readback zero while open and from other offsets
        reg_read(KOFS, "R6");
        reg_read(8'h44, "R6");

        // R5: relock then gating returns
        reg_write(KOFS, 32'h5a5a_5a5a, "R5");
        access(1'b0, 32'h7777_7777, "R9");
        quiet("R9");
        reg_read(KOFS, "R6");

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule